// File: doc/BRIEF.md
# Transmit Buffer with Collision Rewind

This block sits between a host that loads outgoing packet data and a network transmitter that sends that data one byte at a time. The host writes 32-bit words with one enable per byte lane. Its controls are captured on the rising edge and the storage is written on the following edge. Every write uses one whole row of storage, whatever its enables. Lanes whose enable was low are marked empty and never reach the transmitter. A host write can also flag its row as the last row of a packet.

The transmitter reads bytes through a speculative read pointer. Until 64 bytes of the current packet have left, a collision sends that pointer back to the first byte of the packet, so the packet can be sent again from its start. Space is returned to the host only through a committed pointer. That pointer stays at the packet start until the 64-byte point is passed or the packet ends, and then it follows the transmitter. Two registered flags tell the host how much committed space remains: a ready flag compared against a programmable row threshold, and a space flag that warns when less than two rows are left.

Top module: `txb_rewind_fifo`

## Requirements
- R1: After reset, rdy and space_ok are 1 and tx_valid is 0.
- R2: A word whose wr_en is sampled at one rising edge is stored at the next rising edge, so tx_valid can rise no earlier than just after that second edge.
- R3: Each write takes one full row. Bytes leave a row from the lowest enabled lane upward, where lane k is wr_data[8k+7:8k]. Lanes whose enable was 0 are skipped, and a row written with all enables 0 yields no bytes.
- R4: tx_eop is 1 together with the final byte of a row written with wr_last = 1. Once that byte is taken, all rows of the packet are free again.
- R5: rdy is 1 when the committed free row count (32 minus the rows written and not yet committed) is at least cfg_thresh, and 0 otherwise. The flag follows a pointer change by one clock.
- R6: space_ok is 1 when at least two committed rows are free, and 0 once the write that leaves a single free row has been stored.
- R7: A write that reaches storage while all 32 rows are held is dropped and changes neither stored data nor pointers.
- R8: Bytes taken by the transmitter do not raise rdy or space_ok until 64 bytes of the current packet have been taken or the packet has ended.
- R9: A tx_collide pulse before 64 bytes of the packet have been taken makes the next byte the first byte of the packet. A pulse after that point is ignored.
- R10: When tx_collide and tx_rd are both high in the same cycle before the 64-byte point, the rewind wins and the byte offered in that cycle is not counted as taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the host and the transmitter side |
| rst | input | 1 | Synchronous active-high reset |
| cfg_thresh | input | 5 | Free-row threshold for rdy |
| wr_en | input | 1 | Host write request, sampled on the rising edge |
| wr_data | input | 32 | Host write word |
| wr_be | input | 4 | Per-lane byte enables of the write |
| wr_last | input | 1 | Marks the written row as the end of a packet |
| tx_rd | input | 1 | Transmitter takes the offered byte |
| tx_collide | input | 1 | Transmitter saw a collision and asks for a restart |
| tx_byte | output | 8 | Offered byte |
| tx_valid | output | 1 | A byte is offered |
| tx_eop | output | 1 | The offered byte is the last of its packet |
| rdy | output | 1 | Committed free rows meet the threshold |
| space_ok | output | 1 | At least two committed rows are free |

## Verification
A rewind request and a byte take can fall into the same clock. The case that matters most is the one where the take would have been the 64th byte and so would have closed the rewind window. The bench reads a packet up to 63 bytes, then raises tx_rd and tx_collide together in one cycle. It then requires that the next byte offered is byte 0 and that rdy stays low until 64 more bytes have been taken. The same window is also tested from the other side: a collision just after the 64th byte must not move the read position.

// File: rtl/txb_pkg.sv
package txb_pkg;
  // width of one byte lane of a storage row
  localparam int unsigned LANE_W = 8;

  // host-facing flag pair, registered in txb_flags
  typedef struct packed {
    logic ready;
    logic space;
  } txb_flags_t;
endpackage

// File: rtl/txb_wr_port.sv
module txb_wr_port #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AW     = 5,
  localparam int unsigned LANES = DATA_W / txb_pkg::LANE_W,
  localparam int unsigned ROWS  = 1 << AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_be,
  input  logic              wr_last,
  input  logic              full,
  input  logic [AW-1:0]     rd_row,
  output logic [AW:0]       wptr,
  output logic [DATA_W-1:0] rd_data,
  output logic [LANES-1:0]  rd_be,
  output logic              rd_last
);
  logic              en_q;
  logic [DATA_W-1:0] data_q;
  logic [LANES-1:0]  be_q;
  logic              last_q;
  logic              do_wr;

  logic [DATA_W-1:0] data_mem [ROWS];
  logic [LANES-1:0]  be_mem   [ROWS];
  logic              last_mem [ROWS];

  // stage 1: capture host controls
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else begin
      en_q <= wr_en;
    end
    data_q <= wr_data;
    be_q   <= wr_be;
    last_q <= wr_last;
  end

  // stage 2: commit to storage, whole row per write
  assign do_wr = en_q && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
    end else if (do_wr) begin
      wptr <= wptr + (AW+1)'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      data_mem[wptr[AW-1:0]] <= data_q;
      be_mem[wptr[AW-1:0]]   <= be_q;
      last_mem[wptr[AW-1:0]] <= last_q;
    end
  end

  assign rd_data = data_mem[rd_row];
  assign rd_be   = be_mem[rd_row];
  assign rd_last = last_mem[rd_row];

  // R7: a staged write meeting a full buffer leaves the write pointer alone
  a_r7_full_drop: assert property (@(posedge clk) disable iff (rst)
    (en_q && full) |=> $stable(wptr));
endmodule

// File: rtl/txb_rd_ctrl.sv
module txb_rd_ctrl #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AW     = 5,
  parameter int unsigned WINDOW = 64,
  localparam int unsigned LANES = DATA_W / txb_pkg::LANE_W,
  localparam int unsigned SEL_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned CNT_W = $clog2(WINDOW + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [AW:0]              wptr,
  input  logic [DATA_W-1:0]        row_data,
  input  logic [LANES-1:0]         row_be,
  input  logic                     row_last,
  input  logic                     tx_rd,
  input  logic                     tx_collide,
  output logic [AW-1:0]            rd_row,
  output logic [AW:0]              cmt,
  output logic [txb_pkg::LANE_W-1:0] tx_byte,
  output logic                     tx_valid,
  output logic                     tx_eop
);
  logic [AW:0]      spec;
  logic [LANES-1:0] used;
  logic [CNT_W-1:0] cnt;

  logic             avail, past_win, collide_act;
  logic [LANES-1:0] remain, sel_bit;
  logic [SEL_W-1:0] sel;
  logic             one_left, take, skip, row_done, pkt_end;

  assign avail    = (spec != wptr);
  assign remain   = row_be & ~used;
  assign one_left = ($countones(remain) == 1);
  assign past_win = (cnt >= CNT_W'(WINDOW));

  // lowest lane still pending
  always_comb begin
    sel = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (remain[i]) sel = SEL_W'(i);
    end
  end
  assign sel_bit = LANES'(1) << sel;

  assign rd_row   = spec[AW-1:0];
  assign tx_byte  = row_data[sel*txb_pkg::LANE_W +: txb_pkg::LANE_W];
  assign tx_valid = avail && (|remain);
  assign tx_eop   = tx_valid && row_last && one_left;

  assign collide_act = tx_collide && !past_win;
  assign take        = tx_rd && tx_valid && !collide_act;
  assign skip        = avail && !(|remain) && !collide_act;
  assign row_done    = (take && one_left) || skip;
  assign pkt_end     = row_done && row_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      spec <= '0;
      cmt  <= '0;
      used <= '0;
      cnt  <= '0;
    end else if (collide_act) begin
      spec <= cmt;
      used <= '0;
      cnt  <= '0;
    end else begin
      if (take) used <= used | sel_bit;
      if (row_done) begin
        used <= '0;
        spec <= spec + (AW+1)'(1);
      end
      if (take && !past_win) cnt <= cnt + CNT_W'(1);
      if (pkt_end) begin
        cnt <= '0;
        cmt <= spec + (AW+1)'(1);
      end else if (past_win) begin
        cmt <= row_done ? spec + (AW+1)'(1) : spec;
      end
    end
  end

  // R9: a rewind lands exactly on the packet start with no lane consumed
  a_r9_rewind: assert property (@(posedge clk) disable iff (rst)
    collide_act |=> (spec == cmt) && (used == '0));

  // R8: inside the window and before the end, committed space is frozen
  a_r8_commit_hold: assert property (@(posedge clk) disable iff (rst)
    (!past_win && !pkt_end) |=> $stable(cmt));

  // R9: speculative reads stay between the committed point and the writes
  a_r9_spec_bounds: assert property (@(posedge clk) disable iff (rst)
    (AW+1)'(spec - cmt) <= (AW+1)'(wptr - cmt));
endmodule

// File: rtl/txb_flags.sv
module txb_flags #(
  parameter int unsigned AW   = 5,
  parameter int unsigned TH_W = 5,
  localparam int unsigned ROWS = 1 << AW,
  localparam int unsigned CW   = (AW + 1 > TH_W) ? AW + 1 : TH_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW:0]         wptr,
  input  logic [AW:0]         cmt,
  input  logic [TH_W-1:0]     thresh,
  output logic                full,
  output txb_pkg::txb_flags_t flags
);
  logic [AW:0] held;
  logic [AW:0] free_rows;

  assign held      = wptr - cmt;
  assign free_rows = (AW+1)'(ROWS) - held;
  assign full      = (held == (AW+1)'(ROWS));

  always_ff @(posedge clk) begin
    if (rst) begin
      flags.ready <= 1'b1;
      flags.space <= 1'b1;
    end else begin
      flags.ready <= (CW'(free_rows) >= CW'(thresh));
      flags.space <= (free_rows >= (AW+1)'(2));
    end
  end

  // R7: rows held never exceed storage
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    held <= (AW+1)'(ROWS));
endmodule

// File: rtl/txb_rewind_fifo.sv
module txb_rewind_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ROWS   = 32,
  parameter int unsigned TH_W   = 5,
  parameter int unsigned WINDOW = 64,
  localparam int unsigned AW    = $clog2(ROWS),
  localparam int unsigned LANES = DATA_W / txb_pkg::LANE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [TH_W-1:0]            cfg_thresh,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [LANES-1:0]           wr_be,
  input  logic                       wr_last,
  input  logic                       tx_rd,
  input  logic                       tx_collide,
  output logic [txb_pkg::LANE_W-1:0] tx_byte,
  output logic                       tx_valid,
  output logic                       tx_eop,
  output logic                       rdy,
  output logic                       space_ok
);
  logic [AW:0]         wptr, cmt;
  logic [AW-1:0]       rd_row;
  logic [DATA_W-1:0]   row_data;
  logic [LANES-1:0]    row_be;
  logic                row_last;
  logic                full;
  txb_pkg::txb_flags_t flags;

  txb_wr_port #(.DATA_W(DATA_W), .AW(AW)) u_wr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be),
    .wr_last(wr_last), .full(full), .rd_row(rd_row), .wptr(wptr),
    .rd_data(row_data), .rd_be(row_be), .rd_last(row_last)
  );

  txb_rd_ctrl #(.DATA_W(DATA_W), .AW(AW), .WINDOW(WINDOW)) u_rd (
    .clk(clk), .rst(rst), .wptr(wptr), .row_data(row_data), .row_be(row_be),
    .row_last(row_last), .tx_rd(tx_rd), .tx_collide(tx_collide),
    .rd_row(rd_row), .cmt(cmt), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_eop(tx_eop)
  );

  txb_flags #(.AW(AW), .TH_W(TH_W)) u_flags (
    .clk(clk), .rst(rst), .wptr(wptr), .cmt(cmt), .thresh(cfg_thresh),
    .full(full), .flags(flags)
  );

  assign rdy      = flags.ready;
  assign space_ok = flags.space;
endmodule

// File: tb/txb_rewind_fifo_bench.sv
module txb_rewind_fifo_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  cfg_thresh = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic        wr_last = 1'b0;
  logic        tx_rd = 1'b0;
  logic        tx_collide = 1'b0;
  logic [7:0]  tx_byte;
  logic        tx_valid, tx_eop, rdy, space_ok;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] b;
  logic       e, v;

  always #4 clk = ~clk;

  txb_rewind_fifo u_txb_rewind_fifo (
    .clk(clk), .rst(rst), .cfg_thresh(cfg_thresh), .wr_en(wr_en),
    .wr_data(wr_data), .wr_be(wr_be), .wr_last(wr_last), .tx_rd(tx_rd),
    .tx_collide(tx_collide), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_eop(tx_eop), .rdy(rdy), .space_ok(space_ok)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rowv(input int n);
    return {8'(4*n+3), 8'(4*n+2), 8'(4*n+1), 8'(4*n)};
  endfunction

  task automatic do_reset(input logic [4:0] th);
    rst = 1'b1; wr_en = 1'b0; tx_rd = 1'b0; tx_collide = 1'b0;
    cfg_thresh = th;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_word(input logic [31:0] d, input logic [3:0] be, input logic last);
    wr_en = 1'b1; wr_data = d; wr_be = be; wr_last = last;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic rd_byte();
    int w = 0;
    while (!tx_valid && w < 20) begin
      @(negedge clk);
      w++;
    end
    v = tx_valid; b = tx_byte; e = tx_eop;
    tx_rd = 1'b1;
    @(negedge clk);
    tx_rd = 1'b0;
  endtask

  // read n bytes expected to be start..start+n-1, returns mismatch count
  task automatic rd_run(input int start, input int n, output int bad);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      rd_byte();
      if (!v || b != 8'(start + i)) bad++;
    end
  endtask

  task automatic t_reset();
    do_reset(5'd4);
    chk("R1 rdy", int'(rdy), 1);
    chk("R1 space_ok", int'(space_ok), 1);
    chk("R1 tx_valid", int'(tx_valid), 0);
  endtask

  task automatic t_pipeline();
    do_reset(5'd4);
    wr_en = 1'b1; wr_data = 32'h03020100; wr_be = 4'hF; wr_last = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R2 not yet stored", int'(tx_valid), 0);
    @(negedge clk);
    chk("R2 stored one edge later", int'(tx_valid), 1);
    chk("R2 first byte", int'(tx_byte), 0);
    for (int i = 0; i < 4; i++) begin
      rd_byte();
      chk("R3 lane order", int'(b), i);
      chk("R4 eop placement", int'(e), (i == 3) ? 1 : 0);
    end
  endtask

  task automatic t_lanes();
    logic [7:0] exp_b [7] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h77, 8'hF0};
    int bad = 0;
    int eops = 0;
    do_reset(5'd4);
    wr_word(32'h44332211, 4'b1111, 1'b0);
    wr_word(32'h88776655, 4'b0101, 1'b0);
    wr_word(32'hCCBBAA99, 4'b0000, 1'b0);
    wr_word(32'hF0E0D0C0, 4'b1000, 1'b1);
    for (int i = 0; i < 7; i++) begin
      rd_byte();
      if (!v || b != exp_b[i]) bad++;
      if (e) eops = eops + ((i == 6) ? 1 : 100);
    end
    chk("R3 enabled lanes only, empty row skipped", bad, 0);
    chk("R4 single eop on final byte", eops, 1);
    settle();
    chk("R3 nothing beyond valid lanes", int'(tx_valid), 0);
    chk("R4 packet rows freed", int'(space_ok), 1);
  endtask

  task automatic t_fill();
    int bad = 0;
    do_reset(5'd5);
    for (int n = 0; n < 27; n++) wr_word(rowv(n), 4'hF, 1'b0);
    settle();
    chk("R5 free 5 meets threshold 5", int'(rdy), 1);
    wr_word(rowv(27), 4'hF, 1'b0);
    settle();
    chk("R5 free 4 below threshold 5", int'(rdy), 0);
    wr_word(rowv(28), 4'hF, 1'b0);
    wr_word(rowv(29), 4'hF, 1'b0);
    settle();
    chk("R6 free 2 keeps space_ok", int'(space_ok), 1);
    wr_word(rowv(30), 4'hF, 1'b0);
    settle();
    chk("R6 free 1 drops space_ok", int'(space_ok), 0);
    wr_word(rowv(31), 4'hF, 1'b1);
    wr_word(32'hDEADBEEF, 4'hF, 1'b0);
    settle();
    for (int i = 0; i < 128; i++) begin
      rd_byte();
      if (!v || b != 8'(i)) bad++;
      if (e != (i == 127)) bad++;
    end
    chk("R7 stored data intact after dropped write", bad, 0);
    settle();
    chk("R7 dropped write not stored", int'(tx_valid), 0);
  endtask

  task automatic t_window();
    int bad;
    do_reset(5'd5);
    for (int n = 0; n < 30; n++) wr_word(rowv(n), 4'hF, n == 29);
    settle();
    chk("R5 free 2 below threshold", int'(rdy), 0);
    rd_run(0, 40, bad);
    chk("R8 data 0..39", bad, 0);
    settle();
    chk("R8 no credit inside window", int'(rdy), 0);
    rd_run(40, 24, bad);
    chk("R8 data 40..63", bad, 0);
    settle();
    chk("R8 credit after 64 bytes", int'(rdy), 1);
    tx_collide = 1'b1;
    @(negedge clk);
    tx_collide = 1'b0;
    rd_byte();
    chk("R9 late collision ignored", int'(b), 64);
    rd_run(65, 55, bad);
    chk("R9 remainder after ignored collision", bad, 0);
    chk("R4 eop at packet end", int'(e), 1);
  endtask

  task automatic t_collide();
    int bad;
    do_reset(5'd20);
    for (int n = 0; n < 20; n++) wr_word(rowv(n), 4'hF, n == 19);
    settle();
    chk("R5 free 12 below threshold 20", int'(rdy), 0);
    rd_run(0, 10, bad);
    tx_collide = 1'b1;
    @(negedge clk);
    tx_collide = 1'b0;
    rd_byte();
    chk("R9 early collision rewinds", int'(b), 0);
    settle();
    chk("R8 rewind gives no credit", int'(rdy), 0);
    rd_run(1, 62, bad);
    chk("R9 data 1..62 after rewind", bad, 0);
    chk("R10 offered byte before clash", int'(tx_byte), 63);
    tx_rd = 1'b1; tx_collide = 1'b1;
    @(negedge clk);
    tx_rd = 1'b0; tx_collide = 1'b0;
    rd_byte();
    chk("R10 collision beats read", int'(b), 0);
    settle();
    chk("R10 window not closed by clashing read", int'(rdy), 0);
    rd_run(1, 63, bad);
    chk("R10 data 1..63", bad, 0);
    settle();
    chk("R8 credit after 64 bytes", int'(rdy), 1);
    rd_run(64, 16, bad);
    chk("R8 tail 64..79", bad, 0);
    chk("R4 eop on byte 79", int'(e), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pipeline();
    t_lanes();
    t_fill();
    t_window();
    t_collide();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule